// File: doc/BRIEF.md
# Miss Handling Register Entry Controller

This block is a single miss-status entry for a non-blocking cache. It holds one outstanding block address with its size, ready time and order tag. It also keeps two bounded target lists: a primary list, served by the request already issued, and a deferred list, which waits for a re-issue after the response. Every target carries a command code, a ready time, an order tag, a CPU-side or memory-side origin flag and a needs-exclusive bit. Each list also keeps two summary flags, one for exclusive demand and one for upgrades.

A cache controller drives one operation per cycle through `op_i`. The operations are:

- allocate the entry with a first request
- append a CPU target
- insert a memory-side target on behalf of a snoop handler
- set the snoop flags and rewrite upgrades
- mark the entry in service
- pop the primary head
- promote the deferred list
- signal a fill
- free the entry

The snoop decision itself lives elsewhere. The two lists are circular buffers, and promotion exchanges a one-bit selector, so no entries are copied. The current time arrives as a free-running counter.

Top module: `miss_entry_ctrl`

## Requirements
- R1: `OP_ALLOC` (1) stores the request's address, size, ready time and order tag and sets valid. It clears in-service, pending-invalidate and pending-shared, sets the target count to one and places the request in the primary list as a CPU-side target.
- R2: A list's exclusive flag is set by a CPU-side target with the needs-exclusive bit. Its upgrade flag is set by a CPU-side target whose command is upgrade (code 2). A memory-side insert (`OP_SNP_INS`, 3) sets neither flag.
- R3: `OP_ADD` (2) sends the new target to the deferred list when the entry is in service and at least one of these holds: the deferred list is non-empty, pending-invalidate is set, or the primary list lacks exclusive while the new target needs it. In every other case the target goes to the primary list.
- R4: Every accepted target raises the target count by one. Every pop of a non-empty primary list lowers it by one.
- R5: `OP_SNP_FLAGS` (4) with a list's replace input does the following when that list's upgrade flag is set: it rewrites every upgrade command (2) in the list to read-exclusive (1) and clears the flag. When the flag is clear, nothing changes.
- R6: `OP_MARK` (5) behaves in one of two ways:
  - When the primary head has the simple-forward command (3), which needs exactly one target, it pops that target, pulses `freed_o` in the same cycle and leaves in-service clear.
  - Otherwise it sets in-service.
- R7: `OP_PROMOTE` (6) requires an empty primary list. When the deferred list is empty, `promote_ok_o` stays low and nothing changes. Otherwise it does all of the following:
  - raises `promote_ok_o` in the same cycle
  - swaps the lists
  - resets the flags of the list that becomes deferred
  - clears pending-invalidate and pending-shared
  - loads the order tag from the new head
  - sets the ready time to the larger of `now_i` and the new head's ready time
- R8: `OP_FILL` (8) drives `fill_shared_o` high in the same cycle exactly when pending-shared is set.
- R9: `OP_DEALLOC` (9) requires an empty primary list and a zero target count. It clears valid and in-service and resets the flags of both lists.
- R10: An insert into a full list raises `ovf_o` in the same cycle and drops the target. The list contents and the target count do not change.
- R11: Each list returns its targets in insertion order, with every field intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| now_i | input | TIME_W | Free-running current time |
| op_i | input | 4 | Operation code (package enum) |
| req_addr_i | input | ADDR_W | Block address for allocation |
| req_size_i | input | SIZE_W | Request size for allocation |
| req_cmd_i | input | 2 | Target command: 0 read, 1 read-exclusive, 2 upgrade, 3 simple forward |
| req_excl_i | input | 1 | Target needs exclusive ownership |
| req_ready_i | input | TIME_W | Target ready time |
| req_order_i | input | ORD_W | Target order tag |
| snp_inv_i | input | 1 | Set pending-invalidate on `OP_SNP_FLAGS` |
| snp_shr_i | input | 1 | Set pending-shared on `OP_SNP_FLAGS` |
| repl_prim_i | input | 1 | Replace upgrades in the primary list |
| repl_def_i | input | 1 | Replace upgrades in the deferred list |
| valid_o | output | 1 | Entry allocated |
| in_service_o | output | 1 | Request issued |
| addr_o | output | ADDR_W | Stored address |
| size_o | output | SIZE_W | Stored size |
| ready_o | output | TIME_W | Entry ready time |
| order_o | output | ORD_W | Entry order tag |
| ntargets_o | output | CNT_W | Targets held in both lists |
| pend_inv_o | output | 1 | Pending-invalidate |
| pend_shr_o | output | 1 | Pending-shared |
| prim_cnt_o | output | QC_W | Primary list occupancy |
| def_cnt_o | output | QC_W | Deferred list occupancy |
| prim_excl_o | output | 1 | Primary exclusive flag |
| prim_upg_o | output | 1 | Primary upgrade flag |
| def_excl_o | output | 1 | Deferred exclusive flag |
| def_upg_o | output | 1 | Deferred upgrade flag |
| head_cmd_o | output | 2 | Primary head command |
| head_ready_o | output | TIME_W | Primary head ready time |
| head_order_o | output | ORD_W | Primary head order tag |
| head_cpu_o | output | 1 | Primary head is CPU-side |
| head_excl_o | output | 1 | Primary head needs exclusive |
| freed_o | output | 1 | Simple forward popped, entry may be freed |
| promote_ok_o | output | 1 | Promotion performed |
| fill_shared_o | output | 1 | Shared indication for the fill response |
| ovf_o | output | 1 | Insert into a full list dropped |

## Verification
Four strobes are combinational answers to the operation on `op_i` and are due in the cycle the operation is presented: `freed_o`, `promote_ok_o`, `fill_shared_o` and `ovf_o`. The bench samples them a quarter period after driving the inputs, before the capturing edge. Every stored effect passes through exactly one register, so the counts, flags, ready time, order tag and list heads are read at the falling edge after that capturing edge. Promotion's ready time is compared against the `now_i` value captured in the operation's own cycle. Popped heads are compared with a scoreboard of expected targets in the cycle of the pop, before the head advances.

// File: rtl/miss_entry_pkg.sv
package miss_entry_pkg;
   typedef enum logic [1:0] {
      CMD_RD   = 2'd0,
      CMD_RDEX = 2'd1,
      CMD_UPG  = 2'd2,
      CMD_FWD  = 2'd3
   } cmd_e;

   typedef enum logic [3:0] {
      OP_NOP       = 4'd0,
      OP_ALLOC     = 4'd1,
      OP_ADD       = 4'd2,
      OP_SNP_INS   = 4'd3,
      OP_SNP_FLAGS = 4'd4,
      OP_MARK      = 4'd5,
      OP_PROMOTE   = 4'd6,
      OP_POP       = 4'd7,
      OP_FILL      = 4'd8,
      OP_DEALLOC   = 4'd9
   } op_e;
endpackage

// File: rtl/miss_defer_rule.sv
module miss_defer_rule (
   input  logic in_service_i,
   input  logic def_empty_i,
   input  logic pend_inv_i,
   input  logic prim_excl_i,
   input  logic new_excl_i,
   output logic to_def_o
);
   // R3: an issued request cannot absorb the target
   always_comb
      to_def_o = in_service_i &&
                 (!def_empty_i || pend_inv_i || (!prim_excl_i && new_excl_i));
endmodule

// File: rtl/miss_tgt_queue.sv
module miss_tgt_queue #(
   parameter int DEPTH  = 4,
   parameter int TIME_W = 16,
   parameter int ORD_W  = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 push_i,
   input  logic [1:0]           in_cmd_i,
   input  logic [TIME_W-1:0]    in_ready_i,
   input  logic [ORD_W-1:0]     in_order_i,
   input  logic                 in_cpu_i,
   input  logic                 in_excl_i,
   input  logic                 pop_i,
   input  logic                 repl_i,
   input  logic                 flag_clr_i,
   output logic [1:0]           hd_cmd_o,
   output logic [TIME_W-1:0]    hd_ready_o,
   output logic [ORD_W-1:0]     hd_order_o,
   output logic                 hd_cpu_o,
   output logic                 hd_excl_o,
   output logic [$clog2(DEPTH):0] cnt_o,
   output logic                 full_o,
   output logic                 empty_o,
   output logic                 excl_o,
   output logic                 upg_o
);
   import miss_entry_pkg::*;
   localparam int PTR_W = $clog2(DEPTH);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("miss_tgt_queue: DEPTH must be a power of two, at least 2");
   end

   typedef struct packed {
      logic [1:0]        cmd;
      logic [TIME_W-1:0] rdy;
      logic [ORD_W-1:0]  ord;
      logic              cpu;
      logic              excl;
   } tgt_t;

   tgt_t             slots [DEPTH];
   logic [PTR_W:0]   wp_q, rp_q;
   logic             excl_q, upg_q, excl_d, upg_d;
   logic             do_push, do_pop;
   tgt_t             head;

   assign cnt_o   = wp_q - rp_q;
   assign empty_o = (wp_q == rp_q);
   assign full_o  = (wp_q[PTR_W-1:0] == rp_q[PTR_W-1:0]) && (wp_q[PTR_W] != rp_q[PTR_W]);
   assign do_push = push_i && !full_o;
   assign do_pop  = pop_i && !empty_o;
   assign head    = slots[rp_q[PTR_W-1:0]];
   assign hd_cmd_o   = head.cmd;
   assign hd_ready_o = head.rdy;
   assign hd_order_o = head.ord;
   assign hd_cpu_o   = head.cpu;
   assign hd_excl_o  = head.excl;
   assign excl_o = excl_q;
   assign upg_o  = upg_q;

   always_comb begin
      excl_d = flag_clr_i ? 1'b0 : excl_q;
      upg_d  = (flag_clr_i || (repl_i && upg_q)) ? 1'b0 : upg_q;
      if (do_push && in_cpu_i) begin
         excl_d = excl_d | in_excl_i;
         upg_d  = upg_d | (in_cmd_i == CMD_UPG);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_q   <= '0;
         rp_q   <= '0;
         excl_q <= 1'b0;
         upg_q  <= 1'b0;
      end else begin
         if (do_push) wp_q <= wp_q + 1'b1;
         if (do_pop)  rp_q <= rp_q + 1'b1;
         excl_q <= excl_d;
         upg_q  <= upg_d;
      end
   end

   always_ff @(posedge clk) begin
      for (int i = 0; i < DEPTH; i++)
         if (repl_i && upg_q && slots[i].cmd == CMD_UPG) slots[i].cmd <= CMD_RDEX;
      if (do_push)
         slots[wp_q[PTR_W-1:0]] <= '{cmd: in_cmd_i, rdy: in_ready_i, ord: in_order_i,
                                     cpu: in_cpu_i, excl: in_excl_i};
   end

   a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      (push_i && full_o && !pop_i) |=> $stable(cnt_o));
   a_r5_upgrade_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      (repl_i && !push_i) |=> !upg_o);
   a_r11_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_o <= ($clog2(DEPTH)+1)'(DEPTH));
endmodule

// File: rtl/miss_entry_ctrl.sv
module miss_entry_ctrl #(
   parameter int ADDR_W = 32,
   parameter int SIZE_W = 8,
   parameter int TIME_W = 16,
   parameter int ORD_W  = 8,
   parameter int DEPTH  = 4,
   localparam int QC_W  = $clog2(DEPTH) + 1,
   localparam int CNT_W = $clog2(2 * DEPTH + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [TIME_W-1:0]  now_i,
   input  logic [3:0]         op_i,
   input  logic [ADDR_W-1:0]  req_addr_i,
   input  logic [SIZE_W-1:0]  req_size_i,
   input  logic [1:0]         req_cmd_i,
   input  logic               req_excl_i,
   input  logic [TIME_W-1:0]  req_ready_i,
   input  logic [ORD_W-1:0]   req_order_i,
   input  logic               snp_inv_i,
   input  logic               snp_shr_i,
   input  logic               repl_prim_i,
   input  logic               repl_def_i,
   output logic               valid_o,
   output logic               in_service_o,
   output logic [ADDR_W-1:0]  addr_o,
   output logic [SIZE_W-1:0]  size_o,
   output logic [TIME_W-1:0]  ready_o,
   output logic [ORD_W-1:0]   order_o,
   output logic [CNT_W-1:0]   ntargets_o,
   output logic               pend_inv_o,
   output logic               pend_shr_o,
   output logic [QC_W-1:0]    prim_cnt_o,
   output logic [QC_W-1:0]    def_cnt_o,
   output logic               prim_excl_o,
   output logic               prim_upg_o,
   output logic               def_excl_o,
   output logic               def_upg_o,
   output logic [1:0]         head_cmd_o,
   output logic [TIME_W-1:0]  head_ready_o,
   output logic [ORD_W-1:0]   head_order_o,
   output logic               head_cpu_o,
   output logic               head_excl_o,
   output logic               freed_o,
   output logic               promote_ok_o,
   output logic               fill_shared_o,
   output logic               ovf_o
);
   import miss_entry_pkg::*;

   op_e               op;
   logic              sel_q;        // index of the primary list
   logic              p_idx, d_idx;
   logic              valid_q, insvc_q, pinv_q, pshr_q;
   logic [ADDR_W-1:0] addr_q;
   logic [SIZE_W-1:0] size_q;
   logic [TIME_W-1:0] ready_q;
   logic [ORD_W-1:0]  order_q;
   logic [CNT_W-1:0]  ntgt_q;

   logic              q_push [2], q_pop [2], q_repl [2], q_clr [2];
   logic              q_full [2], q_empty [2], q_excl [2], q_upg [2];
   logic              q_hcpu [2], q_hexcl [2];
   logic [1:0]        q_hcmd [2];
   logic [TIME_W-1:0] q_hrdy [2];
   logic [ORD_W-1:0]  q_hord [2];
   logic [QC_W-1:0]   q_cnt  [2];

   logic to_def, push_any, push_tgt, is_fwd, promote_go;
   logic [TIME_W-1:0] promo_ready;

   assign op    = op_e'(op_i);
   assign p_idx = sel_q;
   assign d_idx = ~sel_q;

   miss_defer_rule u_rule (
      .in_service_i (insvc_q),
      .def_empty_i  (q_empty[d_idx]),
      .pend_inv_i   (pinv_q),
      .prim_excl_i  (q_excl[p_idx]),
      .new_excl_i   (req_excl_i),
      .to_def_o     (to_def)
   );

   assign push_any   = (op == OP_ALLOC) || (op == OP_ADD) || (op == OP_SNP_INS);
   assign push_tgt   = (op == OP_ADD && to_def) ? d_idx : p_idx;
   assign is_fwd     = !q_empty[p_idx] && (q_hcmd[p_idx] == CMD_FWD);
   assign promote_go = (op == OP_PROMOTE) && !q_empty[d_idx];
   assign promo_ready = (q_hrdy[d_idx] > now_i) ? q_hrdy[d_idx] : now_i;

   assign ovf_o         = push_any && q_full[push_tgt];
   assign freed_o       = (op == OP_MARK) && is_fwd && !insvc_q;
   assign promote_ok_o  = promote_go;
   assign fill_shared_o = (op == OP_FILL) && pshr_q;

   for (genvar i = 0; i < 2; i++) begin : g_q
      assign q_push[i] = push_any && (push_tgt == 1'(i));
      assign q_pop[i]  = (p_idx == 1'(i)) &&
                         ((op == OP_POP) || ((op == OP_MARK) && is_fwd && !insvc_q));
      assign q_repl[i] = (op == OP_SNP_FLAGS) &&
                         ((p_idx == 1'(i)) ? repl_prim_i : repl_def_i);
      assign q_clr[i]  = (op == OP_ALLOC) || (op == OP_DEALLOC) ||
                         (promote_go && (p_idx == 1'(i)));

      miss_tgt_queue #(.DEPTH(DEPTH), .TIME_W(TIME_W), .ORD_W(ORD_W)) u_q (
         .clk        (clk),
         .rst_n      (rst_n),
         .push_i     (q_push[i]),
         .in_cmd_i   (req_cmd_i),
         .in_ready_i (req_ready_i),
         .in_order_i (req_order_i),
         .in_cpu_i   (op != OP_SNP_INS),
         .in_excl_i  (req_excl_i),
         .pop_i      (q_pop[i]),
         .repl_i     (q_repl[i]),
         .flag_clr_i (q_clr[i]),
         .hd_cmd_o   (q_hcmd[i]),
         .hd_ready_o (q_hrdy[i]),
         .hd_order_o (q_hord[i]),
         .hd_cpu_o   (q_hcpu[i]),
         .hd_excl_o  (q_hexcl[i]),
         .cnt_o      (q_cnt[i]),
         .full_o     (q_full[i]),
         .empty_o    (q_empty[i]),
         .excl_o     (q_excl[i]),
         .upg_o      (q_upg[i])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q   <= 1'b0;
         valid_q <= 1'b0;
         insvc_q <= 1'b0;
         pinv_q  <= 1'b0;
         pshr_q  <= 1'b0;
         addr_q  <= '0;
         size_q  <= '0;
         ready_q <= '0;
         order_q <= '0;
         ntgt_q  <= '0;
      end else begin
         unique case (op)
            OP_ALLOC: begin
               valid_q <= 1'b1;
               insvc_q <= 1'b0;
               pinv_q  <= 1'b0;
               pshr_q  <= 1'b0;
               addr_q  <= req_addr_i;
               size_q  <= req_size_i;
               ready_q <= req_ready_i;
               order_q <= req_order_i;
               ntgt_q  <= CNT_W'(1);
            end
            OP_ADD, OP_SNP_INS: if (!ovf_o) ntgt_q <= ntgt_q + 1'b1;
            OP_SNP_FLAGS: begin
               pinv_q <= pinv_q | snp_inv_i;
               pshr_q <= pshr_q | snp_shr_i;
            end
            OP_MARK: begin
               if (is_fwd && !insvc_q) ntgt_q <= ntgt_q - 1'b1;
               else                    insvc_q <= 1'b1;
            end
            OP_POP: if (!q_empty[p_idx]) ntgt_q <= ntgt_q - 1'b1;
            OP_PROMOTE: if (promote_go) begin
               sel_q   <= ~sel_q;
               pinv_q  <= 1'b0;
               pshr_q  <= 1'b0;
               order_q <= q_hord[d_idx];
               ready_q <= promo_ready;
            end
            OP_DEALLOC: begin
               valid_q <= 1'b0;
               insvc_q <= 1'b0;
            end
            default: ;
         endcase
      end
   end

   assign valid_o      = valid_q;
   assign in_service_o = insvc_q;
   assign addr_o       = addr_q;
   assign size_o       = size_q;
   assign ready_o      = ready_q;
   assign order_o      = order_q;
   assign ntargets_o   = ntgt_q;
   assign pend_inv_o   = pinv_q;
   assign pend_shr_o   = pshr_q;
   assign prim_cnt_o   = q_cnt[p_idx];
   assign def_cnt_o    = q_cnt[d_idx];
   assign prim_excl_o  = q_excl[p_idx];
   assign prim_upg_o   = q_upg[p_idx];
   assign def_excl_o   = q_excl[d_idx];
   assign def_upg_o    = q_upg[d_idx];
   assign head_cmd_o   = q_hcmd[p_idx];
   assign head_ready_o = q_hrdy[p_idx];
   assign head_order_o = q_hord[p_idx];
   assign head_cpu_o   = q_hcpu[p_idx];
   assign head_excl_o  = q_hexcl[p_idx];

   a_r1_alloc_state: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_ALLOC) |=> (valid_o && !in_service_o && !pend_inv_o && !pend_shr_o &&
                            ntargets_o == CNT_W'(1)));
   a_r4_count_up: assert property (@(posedge clk) disable iff (!rst_n)
      ((op == OP_ADD || op == OP_SNP_INS) && !ovf_o) |=> ntargets_o == $past(ntargets_o) + 1'b1);
   a_r6_fwd_single: assert property (@(posedge clk) disable iff (!rst_n)
      freed_o |-> prim_cnt_o == QC_W'(1));
   a_r6_fwd_frees: assert property (@(posedge clk) disable iff (!rst_n)
      freed_o |=> (!in_service_o && prim_cnt_o == '0));
   a_r7_promote_needs_empty: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_PROMOTE) |-> prim_cnt_o == '0);
   a_r7_promote_clears: assert property (@(posedge clk) disable iff (!rst_n)
      promote_ok_o |=> (!pend_inv_o && !pend_shr_o && def_cnt_o == '0 && !def_excl_o));
   a_r9_dealloc_legal: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_DEALLOC) |-> (prim_cnt_o == '0 && ntargets_o == '0));
   a_r9_dealloc_state: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_DEALLOC) |=> (!valid_o && !in_service_o && !prim_excl_o && !def_upg_o));
endmodule

// File: tb/miss_entry_ctrl_test.sv
module miss_entry_ctrl_test;
   import miss_entry_pkg::*;
   localparam int CLK_PER = 10;

   typedef struct {
      logic [1:0]  cmd;
      logic [15:0] rdy;
      logic [7:0]  ord;
      logic        cpu;
      logic        excl;
   } exp_t;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic [15:0] now_i = '0;
   logic [3:0]  op_i = OP_NOP;
   logic [31:0] req_addr_i = '0;
   logic [7:0]  req_size_i = '0;
   logic [1:0]  req_cmd_i = '0;
   logic        req_excl_i = 1'b0;
   logic [15:0] req_ready_i = '0;
   logic [7:0]  req_order_i = '0;
   logic        snp_inv_i = 1'b0, snp_shr_i = 1'b0, repl_prim_i = 1'b0, repl_def_i = 1'b0;

   logic        valid_o, in_service_o, pend_inv_o, pend_shr_o;
   logic [31:0] addr_o;
   logic [7:0]  size_o, order_o, head_order_o;
   logic [15:0] ready_o, head_ready_o;
   logic [3:0]  ntargets_o;
   logic [2:0]  prim_cnt_o, def_cnt_o;
   logic        prim_excl_o, prim_upg_o, def_excl_o, def_upg_o;
   logic [1:0]  head_cmd_o;
   logic        head_cpu_o, head_excl_o, freed_o, promote_ok_o, fill_shared_o, ovf_o;

   miss_entry_ctrl uut (.*);

   always #(CLK_PER / 2) clk = ~clk;
   always @(posedge clk) now_i <= now_i + 1'b1;

   int   n_chk = 0, n_fail = 0;
   bit   done = 1'b0;
   exp_t sb_p[$], sb_d[$];
   logic s_freed, s_ok, s_fill, s_ovf;
   logic [15:0] s_now;

   task automatic chk(input string tag, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // driver: present one operation, snapshot same-cycle strobes, settle state
   task automatic issue(input op_e op, input logic [1:0] cmd = 2'd0, input logic excl = 1'b0,
                        input logic [15:0] rdy = '0, input logic [7:0] ord = '0);
      @(negedge clk);
      op_i = op; req_cmd_i = cmd; req_excl_i = excl; req_ready_i = rdy; req_order_i = ord;
      #(CLK_PER / 4);
      s_freed = freed_o; s_ok = promote_ok_o; s_fill = fill_shared_o; s_ovf = ovf_o;
      s_now = now_i;
      if (op == OP_POP) begin : mon
         exp_t e;
         e = sb_p.pop_front();
         chk("R11 head cmd",   head_cmd_o,   e.cmd);
         chk("R11 head ready", head_ready_o, e.rdy);
         chk("R11 head order", head_order_o, e.ord);
         chk("R11 head cpu",   head_cpu_o,   e.cpu);
         chk("R11 head excl",  head_excl_o,  e.excl);
      end
      @(negedge clk);
      op_i = OP_NOP; snp_inv_i = 0; snp_shr_i = 0; repl_prim_i = 0; repl_def_i = 0;
   endtask

   function automatic exp_t mk(input logic [1:0] c, input logic [15:0] r, input logic [7:0] o,
                               input logic cpu, input logic x);
      exp_t e;
      e.cmd = c; e.rdy = r; e.ord = o; e.cpu = cpu; e.excl = x;
      return e;
   endfunction

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_fail++; n_chk++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 reset valid", valid_o, 0);
      chk("R4 reset count", ntargets_o, 0);
      chk("R1 reset in service", in_service_o, 0);

      // ---- scenario 1: deferral, overflow, fill, promotion ----
      req_addr_i = 32'h0000_1A40; req_size_i = 8'd64;
      issue(OP_ALLOC, CMD_RD, 0, 16'd100, 8'd5); sb_p.push_back(mk(CMD_RD, 100, 5, 1, 0));
      chk("R1 valid", valid_o, 1);
      chk("R1 addr", addr_o, 32'h0000_1A40);
      chk("R1 size", size_o, 64);
      chk("R1 ready", ready_o, 100);
      chk("R1 order", order_o, 5);
      chk("R1 count", ntargets_o, 1);
      chk("R1 primary occupancy", prim_cnt_o, 1);
      chk("R1 pending flags", {pend_inv_o, pend_shr_o}, 0);

      issue(OP_ADD, CMD_UPG, 1, 16'd110, 8'd6); sb_p.push_back(mk(CMD_UPG, 110, 6, 1, 1));
      chk("R3 idle add to primary", prim_cnt_o, 2);
      chk("R2 primary exclusive set", prim_excl_o, 1);
      chk("R2 primary upgrade set", prim_upg_o, 1);
      chk("R4 count after add", ntargets_o, 2);

      repl_prim_i = 1'b1;
      issue(OP_SNP_FLAGS); sb_p[1].cmd = CMD_RDEX;
      chk("R5 primary upgrade cleared", prim_upg_o, 0);

      issue(OP_SNP_INS, CMD_RD, 0, 16'd120, 8'd7); sb_p.push_back(mk(CMD_RD, 120, 7, 0, 0));
      chk("R4 count after snoop insert", ntargets_o, 3);

      issue(OP_MARK);
      chk("R6 no free on normal request", s_freed, 0);
      chk("R6 in service set", in_service_o, 1);

      issue(OP_ADD, CMD_RDEX, 1, 16'd130, 8'd8); sb_p.push_back(mk(CMD_RDEX, 130, 8, 1, 1));
      chk("R3 exclusive covered goes primary", prim_cnt_o, 4);
      chk("R3 deferred still empty", def_cnt_o, 0);

      issue(OP_ADD, CMD_RD, 0, 16'd140, 8'd9);
      chk("R10 overflow strobe", s_ovf, 1);
      chk("R10 count unchanged", ntargets_o, 4);
      chk("R10 primary unchanged", prim_cnt_o, 4);

      snp_inv_i = 1'b1; snp_shr_i = 1'b1;
      issue(OP_SNP_FLAGS);
      chk("R3 pending invalidate recorded", pend_inv_o, 1);

      issue(OP_ADD, CMD_RD, 0, 16'd3000, 8'd10); sb_d.push_back(mk(CMD_RD, 3000, 10, 1, 0));
      chk("R3 pending invalidate defers", def_cnt_o, 1);
      chk("R4 count with deferred", ntargets_o, 5);

      issue(OP_FILL);
      chk("R8 fill shared asserted", s_fill, 1);

      for (int k = 0; k < 4; k++) issue(OP_POP);
      chk("R4 count after pops", ntargets_o, 1);

      issue(OP_PROMOTE); sb_p = sb_d; sb_d = {};
      chk("R7 promote strobe", s_ok, 1);
      chk("R7 order from head", order_o, 10);
      chk("R7 ready from head", ready_o, (3000 > s_now) ? 3000 : s_now);
      chk("R7 pending cleared", {pend_inv_o, pend_shr_o}, 0);
      chk("R7 lists swapped", {prim_cnt_o, def_cnt_o}, {3'd1, 3'd0});
      chk("R7 deferred flags reset", {def_excl_o, def_upg_o}, 0);

      issue(OP_FILL);
      chk("R8 fill shared cleared", s_fill, 0);
      issue(OP_POP);
      issue(OP_PROMOTE);
      chk("R7 empty deferred refuses", s_ok, 0);
      chk("R7 order kept", order_o, 10);
      issue(OP_DEALLOC);
      chk("R9 valid cleared", valid_o, 0);
      chk("R9 in service cleared", in_service_o, 0);

      // ---- scenario 2: simple forward ----
      issue(OP_ALLOC, CMD_FWD, 0, 16'd0, 8'd1);
      issue(OP_MARK);
      chk("R6 forward frees", s_freed, 1);
      chk("R6 forward not in service", in_service_o, 0);
      chk("R6 forward popped", {ntargets_o, prim_cnt_o}, 0);
      issue(OP_DEALLOC);

      // ---- scenario 3: exclusivity deferral and deferred upgrade rewrite ----
      issue(OP_ALLOC, CMD_RD, 0, 16'd0, 8'd20); sb_p.push_back(mk(CMD_RD, 0, 20, 1, 0));
      issue(OP_SNP_INS, CMD_RDEX, 1, 16'd2, 8'd21); sb_p.push_back(mk(CMD_RDEX, 2, 21, 0, 1));
      chk("R2 memory side sets no flag", prim_excl_o, 0);
      issue(OP_MARK);
      issue(OP_ADD, CMD_UPG, 1, 16'd5, 8'd22); sb_d.push_back(mk(CMD_UPG, 5, 22, 1, 1));
      chk("R3 exclusive need defers", def_cnt_o, 1);
      chk("R2 deferred flags", {def_excl_o, def_upg_o}, 2'b11);
      issue(OP_ADD, CMD_RD, 0, 16'd6, 8'd23); sb_d.push_back(mk(CMD_RD, 6, 23, 1, 0));
      chk("R3 non-empty deferred defers", def_cnt_o, 2);
      repl_def_i = 1'b1; repl_prim_i = 1'b1;
      issue(OP_SNP_FLAGS); sb_d[0].cmd = CMD_RDEX;
      chk("R5 deferred upgrade cleared", def_upg_o, 0);
      issue(OP_POP); issue(OP_POP);
      issue(OP_PROMOTE); sb_p = sb_d; sb_d = {};
      chk("R7 promote strobe 2", s_ok, 1);
      chk("R7 ready from time", ready_o, (s_now > 5) ? s_now : 5);
      chk("R7 order 2", order_o, 22);
      issue(OP_POP); issue(OP_POP);
      chk("R4 count drained", ntargets_o, 0);
      issue(OP_DEALLOC);
      chk("R9 freed again", valid_o, 0);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule